// File: doc/BRIEF.md
# LPC I/O Target

This block sits on the peripheral side of a nibble-wide, multiplexed low pin count bus and answers host-issued single-byte I/O reads and writes. It watches the frame strobe and the four data lines, checks that a cycle is a standard I/O cycle, collects a 16-bit port address and compares it with a window given by `win_base` and the parameter `WIN_BITS`. On a hit it hands the access to back-end registers through a strobe interface. Then, once the host has passed the bus over, it drives the handshake and any read data back onto the nibble bus through an output enable.

The back end answers through `loc_ready`. While it holds `loc_ready` low, the target keeps inserting short wait states. Cycles with any other start code, type or address pass by without the target ever driving the bus. If the host holds the frame strobe low in the middle of a cycle, the target lets go of the bus at once, and after a long strobe it returns to idle.

Top module: `lpc_io_target`

## Requirements
- R1: After reset, `lad_oe`, `loc_wr` and `loc_rd` are all 0 until a matching cycle runs.
- R2: A cycle begins while `frame_n` is low. Only the nibble present in the last low clock counts as the start code, and only 0000 is accepted. Any other final nibble makes the target ignore the cycle, even if an earlier low clock carried 0000.
- R3: The first nibble after `frame_n` rises gives the type in bits [3:2] (00 means I/O), the direction in bit 1 (1 means write, 0 means read), and bit 0 must be 0. Only 0000 (I/O read) and 0010 (I/O write) are served; every other nibble is ignored.
- R4: The address arrives as four nibbles, most significant first. It hits when bits [15:WIN_BITS] equal those of `win_base`. During the strobe cycle, `loc_addr` holds the full address.
- R5: A write carries its byte as two nibbles, low nibble first. `loc_wr` goes high for exactly one clock in the first host turnaround cycle, with `loc_wdata` valid.
- R6: After the address (read) or the data (write), the target stays off the bus for two turnaround clocks. It drives a SYNC nibble in the third clock.
- R7: SYNC is 0101 (short wait) in every clock where `loc_ready` is low and 0000 (ready) in the clock where it is high. Both codes have even parity.
- R8: `loc_rd` goes high for one clock in the clock after the last address nibble. After the ready SYNC, the target drives the byte present on `loc_rdata` in that clock, low nibble then high nibble, then 1111 for one clock, and then releases the bus.
- R9: On a write, the ready SYNC is followed by one clock of 1111 and then the bus is released.
- R10: An address outside the window causes no strobe and no drive of the bus at any point.
- R11: `lad_oe` is 0 in every clock where `frame_n` is low and in the clock after it. If `frame_n` stays low for four or more clocks, the nibble that follows is not taken as a cycle type, whatever the low nibbles were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | Active-low frame strobe from the host |
| lad_in | input | 4 | Nibble sampled from the shared bus |
| lad_out | output | 4 | Nibble driven by the target |
| lad_oe | output | 1 | Output enable for `lad_out` |
| win_base | input | 16 | Base of the decoded I/O window |
| loc_addr | output | 16 | Captured I/O address |
| loc_wdata | output | 8 | Captured write byte |
| loc_wr | output | 1 | One-clock write strobe |
| loc_rd | output | 1 | One-clock read request |
| loc_rdata | input | 8 | Read byte from the back end |
| loc_ready | input | 1 | Back end done; ends the wait states |

## Verification
Every port address inside a 16-entry window is tried with both reads and writes, each with its own data byte and a wait count cycling from zero to three. This shows whether nibble order, strobe timing and wait-state length are each right. Addresses one below the window, one above it, and with a single high bit flipped tell a correct window compare apart from one that drops bits. All fifteen wrong start codes, a multi-clock start whose last nibble is or is not 0000, and all fourteen wrong type nibbles show that nothing but the final start nibble and the exact type code arm the target. A long frame strobe is applied at each clock of a write, from the type nibble through the SYNC wait states. This separates an immediate release with a return to idle from a target that keeps driving or resumes the old cycle.

// File: rtl/lpc_io_target.sv
module lpc_io_target #(
  parameter int WIN_BITS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic [3:0]  lad_in,
  output logic [3:0]  lad_out,
  output logic        lad_oe,
  input  logic [15:0] win_base,
  output logic [15:0] loc_addr,
  output logic [7:0]  loc_wdata,
  output logic        loc_wr,
  output logic        loc_rd,
  input  logic [7:0]  loc_rdata,
  input  logic        loc_ready
);

  localparam logic [15:0] HI_MASK = 16'hFFFF << WIN_BITS;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR, S_WDAT, S_TAR1, S_TAR2, S_SYNC, S_RDAT, S_TURN
  } state_t;

  state_t      st;
  logic [2:0]  lowcnt;
  logic        start_ok;
  logic        is_wr;
  logic [1:0]  cnt;
  logic [15:0] addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic [15:0] addr_nx;
  logic        hit_nx;
  logic        drive;

  assign addr_nx   = {addr[11:0], lad_in};
  assign hit_nx    = ((addr_nx ^ win_base) & HI_MASK) == 16'h0000;
  assign loc_addr  = addr;
  assign loc_wdata = wdata;

  assign drive  = (st == S_SYNC) || (st == S_RDAT) || (st == S_TURN);
  assign lad_oe = drive && frame_n;

  always_comb begin
    lad_out = 4'hF;
    case (st)
      S_SYNC:  lad_out = loc_ready ? 4'h0 : 4'h5;
      S_RDAT:  lad_out = (cnt == 2'd0) ? rdata[3:0] : rdata[7:4];
      default: lad_out = 4'hF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      lowcnt   <= 3'd0;
      start_ok <= 1'b0;
      is_wr    <= 1'b0;
      cnt      <= 2'd0;
      addr     <= 16'h0000;
      wdata    <= 8'h00;
      rdata    <= 8'h00;
      loc_wr   <= 1'b0;
      loc_rd   <= 1'b0;
    end else begin
      loc_wr <= 1'b0;
      loc_rd <= 1'b0;
      if (!frame_n) begin
        st       <= S_START;
        start_ok <= (lad_in == 4'h0);
        if (st != S_START) lowcnt <= 3'd1;
        else if (lowcnt != 3'd4) lowcnt <= lowcnt + 3'd1;
      end else begin
        case (st)
          S_START: begin
            if (start_ok && lowcnt != 3'd4 && lad_in[3:2] == 2'b00 && !lad_in[0]) begin
              st    <= S_ADDR;
              is_wr <= lad_in[1];
              cnt   <= 2'd0;
            end else begin
              st <= S_IDLE;
            end
          end
          S_ADDR: begin
            addr <= addr_nx;
            cnt  <= cnt + 2'd1;
            if (cnt == 2'd3) begin
              if (!hit_nx) begin
                st <= S_IDLE;
              end else if (is_wr) begin
                st  <= S_WDAT;
                cnt <= 2'd0;
              end else begin
                st     <= S_TAR1;
                loc_rd <= 1'b1;
              end
            end
          end
          S_WDAT: begin
            cnt <= cnt + 2'd1;
            if (cnt == 2'd0) begin
              wdata[3:0] <= lad_in;
            end else begin
              wdata[7:4] <= lad_in;
              st         <= S_TAR1;
              loc_wr     <= 1'b1;
            end
          end
          S_TAR1: st <= S_TAR2;
          S_TAR2: st <= S_SYNC;
          S_SYNC: begin
            if (loc_ready) begin
              rdata <= loc_rdata;
              cnt   <= 2'd0;
              st    <= is_wr ? S_TURN : S_RDAT;
            end
          end
          S_RDAT: begin
            cnt <= cnt + 2'd1;
            if (cnt == 2'd1) st <= S_TURN;
          end
          S_TURN:  st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  p_release_after_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> !lad_oe);

  p_strobe_in_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_wr || loc_rd) |-> (((loc_addr ^ win_base) & HI_MASK) == 16'h0000));

  p_write_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    loc_wr |=> !loc_wr);

  p_read_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    loc_rd |=> !loc_rd);

  p_strobe_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(loc_wr && loc_rd));

  p_sync_on_third_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TAR2 && frame_n) |=> (!frame_n || lad_oe));

  p_sync_parity_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SYNC && lad_oe) |-> (^lad_out) == 1'b0);

  p_release_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lad_oe) && frame_n && $past(frame_n)) |-> $past(lad_out) == 4'hF);

endmodule

// File: tb/lpc_io_target_tb_top.sv
module lpc_io_target_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic [3:0]  host_nib = 4'hF;
  logic        host_en = 1'b0;
  logic [3:0]  lad_in;
  logic [3:0]  lad_out;
  logic        lad_oe;
  logic [15:0] win_base = 16'h02E0;
  logic [15:0] loc_addr;
  logic [7:0]  loc_wdata;
  logic        loc_wr;
  logic        loc_rd;
  logic [7:0]  loc_rdata = 8'h00;
  logic        loc_ready = 1'b0;
  logic        rdy_next = 1'b0;

  int vec = 0;
  int mis = 0;

  always #10 clk = ~clk;

  assign lad_in = lad_oe ? lad_out : (host_en ? host_nib : 4'hF);

  lpc_io_target #(.WIN_BITS(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
    .lad_out(lad_out), .lad_oe(lad_oe), .win_base(win_base),
    .loc_addr(loc_addr), .loc_wdata(loc_wdata), .loc_wr(loc_wr),
    .loc_rd(loc_rd), .loc_rdata(loc_rdata), .loc_ready(loc_ready)
  );

  function automatic logic [15:0] obs();
    return {11'd0, lad_oe, lad_out};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    vec++;
    if (!ok) begin
      mis++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic f, input logic [3:0] n, input logic en);
    @(negedge clk);
    frame_n   = f;
    host_nib  = n;
    host_en   = en;
    loc_ready = rdy_next;
    #1;
  endtask

  task automatic io(input bit wr, input logic [15:0] a, input logic [7:0] d, input int w, input int nlow);
    loc_rdata = d;
    rdy_next  = 1'b0;
    for (int i = 0; i < nlow; i++) step(1'b0, (i == nlow - 1) ? 4'h0 : 4'h5, 1'b1);
    step(1'b1, wr ? 4'h2 : 4'h0, 1'b1);
    for (int j = 0; j < 4; j++) step(1'b1, a[15 - 4*j -: 4], 1'b1);
    if (wr) begin
      step(1'b1, d[3:0], 1'b1);
      step(1'b1, d[7:4], 1'b1);
    end
    step(1'b1, 4'hF, 1'b1);
    if (wr) begin
      chk(loc_wr && !loc_rd, "R5 write strobe", {14'd0, loc_wr, loc_rd}, 16'h0002);
      chk(loc_wdata == d, "R5 write data", {8'd0, loc_wdata}, {8'd0, d});
    end else begin
      chk(loc_rd && !loc_wr, "R8 read strobe", {14'd0, loc_wr, loc_rd}, 16'h0001);
    end
    chk(loc_addr == a, "R4 address", loc_addr, a);
    chk(!lad_oe, "R6 first turnaround", obs(), 16'h000F);
    step(1'b1, 4'hF, 1'b0);
    chk(!lad_oe && !loc_wr && !loc_rd, "R6 second turnaround", obs(), 16'h000F);
    for (int i = 0; i < w; i++) begin
      step(1'b1, 4'hF, 1'b0);
      chk(obs() == 16'h0015, "R7 short wait", obs(), 16'h0015);
    end
    rdy_next = 1'b1;
    step(1'b1, 4'hF, 1'b0);
    chk(obs() == 16'h0010, "R7 ready sync", obs(), 16'h0010);
    rdy_next = 1'b0;
    if (!wr) begin
      step(1'b1, 4'hF, 1'b0);
      chk(obs() == {12'h001, d[3:0]}, "R8 data low", obs(), {12'h001, d[3:0]});
      step(1'b1, 4'hF, 1'b0);
      chk(obs() == {12'h001, d[7:4]}, "R8 data high", obs(), {12'h001, d[7:4]});
    end
    step(1'b1, 4'hF, 1'b0);
    chk(obs() == 16'h001F, wr ? "R9 release drive" : "R8 release drive", obs(), 16'h001F);
    step(1'b1, 4'hF, 1'b0);
    chk(!lad_oe, wr ? "R9 released" : "R8 released", obs(), 16'h000F);
  endtask

  task automatic silent(input logic [3:0] s0, input logic [3:0] s1, input logic [3:0] ct,
                        input logic [15:0] a, input string tag);
    bit ok = 1'b1;
    rdy_next = 1'b1;
    step(1'b0, s0, 1'b1);
    ok &= !lad_oe;
    step(1'b0, s1, 1'b1);
    ok &= !lad_oe;
    step(1'b1, ct, 1'b1);
    ok &= !lad_oe;
    for (int j = 0; j < 4; j++) begin
      step(1'b1, a[15 - 4*j -: 4], 1'b1);
      ok &= !lad_oe && !loc_wr && !loc_rd;
    end
    for (int j = 0; j < 3; j++) begin
      step(1'b1, 4'h6, 1'b1);
      ok &= !lad_oe && !loc_wr && !loc_rd;
    end
    for (int j = 0; j < 7; j++) begin
      step(1'b1, 4'hF, 1'b0);
      ok &= !lad_oe && !loc_wr && !loc_rd;
    end
    rdy_next = 1'b0;
    chk(ok, tag, {15'd0, ok}, 16'h0001);
  endtask

  task automatic abort_at(input int k);
    logic [3:0] nib [14];
    logic       en  [14];
    bit ok_rel = 1'b1;
    bit ok_idle = 1'b1;
    nib = '{4'h0, 4'h2, 4'h0, 4'h2, 4'hE, 4'h3, 4'h5, 4'hA, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF};
    en  = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
    rdy_next = 1'b0;
    for (int i = 0; i < k; i++) step((i == 0) ? 1'b0 : 1'b1, nib[i], en[i]);
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 4'h0, 1'b1);
      ok_rel &= !lad_oe;
      if (i > 0) ok_rel &= !loc_wr && !loc_rd;
    end
    step(1'b1, 4'h2, 1'b1);
    ok_rel &= !lad_oe && !loc_wr && !loc_rd;
    chk(ok_rel, "R11 release on long frame", {15'd0, ok_rel}, 16'h0001);
    rdy_next = 1'b1;
    for (int j = 0; j < 4; j++) begin
      step(1'b1, nib[2 + j], 1'b1);
      ok_idle &= !lad_oe && !loc_wr && !loc_rd;
    end
    for (int j = 0; j < 2; j++) begin
      step(1'b1, 4'h9, 1'b1);
      ok_idle &= !lad_oe && !loc_wr && !loc_rd;
    end
    for (int j = 0; j < 7; j++) begin
      step(1'b1, 4'hF, 1'b0);
      ok_idle &= !lad_oe && !loc_wr && !loc_rd;
    end
    rdy_next = 1'b0;
    chk(ok_idle, "R11 idle after long frame", {15'd0, ok_idle}, 16'h0001);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    mis++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 4'hF, 1'b0);
      chk(!lad_oe && !loc_wr && !loc_rd, "R1 reset state", {13'd0, lad_oe, loc_wr, loc_rd}, 16'h0000);
    end

    for (int wr = 0; wr < 2; wr++)
      for (int off = 0; off < 16; off++)
        io(wr[0], win_base + 16'(off), 8'(8'h3C + off * 8'h17 + wr * 8'h81), off % 4, 1);

    silent(4'h0, 4'h0, 4'h2, win_base - 16'd1,  "R10 below window");
    silent(4'h0, 4'h0, 4'h0, win_base + 16'd16, "R10 above window");
    silent(4'h0, 4'h0, 4'h2, win_base ^ 16'h8000, "R10 top bit differs");
    silent(4'h0, 4'h0, 4'h0, win_base ^ 16'h0010, "R10 lowest compared bit differs");
    io(1'b1, win_base + 16'd7, 8'hC3, 1, 1);

    for (int s = 1; s < 16; s++)
      silent(4'h0, 4'(s), 4'h2, win_base + 16'd2, "R2 non-zero start code");
    silent(4'h0, 4'h5, 4'h0, win_base + 16'd3, "R2 start code not in last low clock");
    io(1'b0, win_base + 16'd9, 8'h5A, 2, 3);
    io(1'b1, win_base + 16'd4, 8'hA5, 0, 2);

    for (int c = 0; c < 16; c++)
      if (c != 0 && c != 2)
        silent(4'h0, 4'h0, 4'(c), win_base + 16'd1, "R3 unsupported type nibble");

    for (int k = 1; k < 14; k++) begin
      abort_at(k);
      io(1'b1, win_base + 16'(k), 8'(k * 8'h11), 0, 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
    $finish;
  end

endmodule